// File: doc/BRIEF.md
# Reduction Flow Table Controller

This block keeps the per-flow state that one router node needs to take part in an in-network reduction tree. Each flow is a dynamic tree node. It is created by the first update that passes through the node. It learns its upstream port from that update, learns its downstream ports from the updates it forwards, and counts the operations it runs locally. It also folds every local result and every child result into one running partial value. Merging uses a combine function picked by the flow's opcode.

Events arrive on one channel, at most one per cycle. When the flow has been asked to gather, has no outstanding children and every local request has completed, the node emits one response carrying the partial value toward its parent port and frees the entry. Gather requests are echoed as a port mask naming the children to which the request must be replicated. Packet parsing, route computation and the local arithmetic engines are outside the block.

Top module: `redtab_top`

## Requirements
- R1: After reset every entry is empty, `ev_ready` is high and neither `rsp_valid` nor `gq_valid` is asserted.
- R2: An update (kind 1 local or kind 2 forward) for a flow not in the table takes the lowest free entry, records `ev_in_port` as the parent and sets the partial value to the identity of `ev_op` (opcodes: 0 sum, 1 xor, 2 and, 3 unsigned min, 4 unsigned max; the identity is 0 for sum, xor and max and all ones for and and min).
- R3: A forward update (kind 2) sets the child flag of `ev_out_port` in the flow's entry.
- R4: A local update (kind 1) raises the issued count by one. A completion (kind 3) raises the completed count by one and merges `ev_data` into the partial value with the flow's opcode.
- R5: When the gather flag is set, no child flag is set and the issued count equals the completed count after a kind 3, 4 or 5 event, `rsp_valid` pulses in the next cycle with the flow, the parent port and the partial value, and the entry is freed so that a later update for that flow starts afresh.
- R6: A gather request (kind 4) with issued above completed produces no response. The response follows the completion that makes the counts equal.
- R7: A gather response (kind 5) from port `ev_in_port` whose child flag is set merges `ev_data` and clears that flag. From a port whose flag is clear it changes nothing.
- R8: With all 16 entries occupied, an update for an unknown flow holds `ev_ready` low. Events for flows already in the table keep `ev_ready` high.
- R9: Kind 3, 4 and 5 events for a flow not in the table are dropped with no output and no state change.
- R10: A gather request sets the gather flag. In the next cycle it pulses `gq_valid` with `gq_mask` equal to the flow's set child flags, and only when that mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event accepted this cycle |
| ev_kind | input | 3 | 1 local update, 2 forward update, 3 completion, 4 gather request, 5 gather response |
| ev_flow | input | 8 | Flow identifier |
| ev_op | input | 3 | Opcode, used at allocation |
| ev_in_port | input | 2 | Arrival port (parent on allocation, child on gather response) |
| ev_out_port | input | 2 | Outgoing port of a forward update |
| ev_data | input | 16 | Value of a completion or gather response |
| rsp_valid | output | 1 | Response toward parent, entry freed |
| rsp_flow | output | 8 | Flow of the response |
| rsp_port | output | 2 | Parent port |
| rsp_data | output | 16 | Final partial value |
| gq_valid | output | 1 | Gather request to replicate |
| gq_flow | output | 8 | Flow of the replicated request |
| gq_mask | output | 4 | Ports to replicate to |

## Verification
The hardest condition to reach is a full table. It needs sixteen distinct live flows, none of which may drain while the stall is probed. The bench allocates them with forward updates only, so each holds a child flag and can never meet the release condition. It then presents a seventeenth flow and withdraws it, frees one flow through a gather request and a single child response, and retries. The other hard case is a gather that waits on both children and local work. There, a stray child response and the last completion must land in the right order for the merged value to be exact.

// File: rtl/redtab_pkg.sv
// Shared encodings for the reduction flow table.
// Assumes event kind and opcode are both carried on 3-bit fields.
package redtab_pkg;

    typedef enum logic [2:0] {
        EV_NONE       = 3'd0,
        EV_UPD_LOCAL  = 3'd1,
        EV_UPD_FWD    = 3'd2,
        EV_COMPLETE   = 3'd3,
        EV_GATHER_REQ = 3'd4,
        EV_GATHER_RSP = 3'd5
    } ev_kind_e;

    typedef enum logic [2:0] {
        OP_SUM = 3'd0,
        OP_XOR = 3'd1,
        OP_AND = 3'd2,
        OP_MIN = 3'd3,
        OP_MAX = 3'd4
    } red_op_e;

endpackage

// File: rtl/redtab_cam.sv
// Fully associative flow lookup plus lowest-free-slot picker.
// Assumes at most one valid entry holds a given flow identifier.
module redtab_cam #(
    parameter int ENTRIES = 16,
    parameter int FLOW_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             valid_i,
    input  logic [ENTRIES-1:0][FLOW_W-1:0] flow_i,
    input  logic [FLOW_W-1:0]              key_i,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               hit_idx_o,
    output logic                           free_any_o,
    output logic [IDX_W-1:0]               free_idx_o
);

    logic [ENTRIES-1:0] match_v;

    // Per-entry compare of the stored flow against the key.
    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match_v[g] = valid_i[g] && (flow_i[g] == key_i);
        end
    endgenerate

    // Encode the matching slot and the lowest empty slot.
    always_comb begin
        hit_o      = |match_v;
        free_any_o = ~&valid_i;
        hit_idx_o  = '0;
        free_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_v[i]) hit_idx_o = IDX_W'(i);
            if (!valid_i[i]) free_idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/redtab_alu.sv
// Combine function for partial results, selected by opcode.
// Assumes unsigned operands; unknown opcodes keep the accumulator.
module redtab_alu #(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] val_i,
    output logic [DATA_W-1:0] res_o
);
    import redtab_pkg::*;

    // Select the reduction operator.
    always_comb begin
        case (red_op_e'(op_i))
            OP_SUM:  res_o = acc_i + val_i;
            OP_XOR:  res_o = acc_i ^ val_i;
            OP_AND:  res_o = acc_i & val_i;
            OP_MIN:  res_o = (val_i < acc_i) ? val_i : acc_i;
            OP_MAX:  res_o = (val_i > acc_i) ? val_i : acc_i;
            default: res_o = acc_i;
        endcase
    end

endmodule

// File: rtl/redtab_entry.sv
// One tree-node record: flow, opcode, parent, child flags, counters,
// gather flag and partial value. Applies the broadcast event when
// selected and signals drain when the release condition is met.
// Assumes sel_i is only raised on a free slot for an allocating update
// or on the slot that matched the event's flow.
module redtab_entry #(
    parameter int FLOW_W = 8,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int NPORTS = 4,
    localparam int PORT_W = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic [2:0]        kind_i,
    input  logic [FLOW_W-1:0] flow_i,
    input  logic [2:0]        op_i,
    input  logic [PORT_W-1:0] in_port_i,
    input  logic [PORT_W-1:0] out_port_i,
    input  logic [DATA_W-1:0] merged_i,
    output logic              valid_o,
    output logic [FLOW_W-1:0] flow_o,
    output logic [2:0]        op_o,
    output logic [PORT_W-1:0] parent_o,
    output logic [NPORTS-1:0] children_o,
    output logic [DATA_W-1:0] res_o,
    output logic [DATA_W-1:0] nres_o,
    output logic              drain_o
);
    import redtab_pkg::*;

    logic              valid_q, n_valid;
    logic [FLOW_W-1:0] flow_q, n_flow;
    logic [2:0]        op_q, n_op;
    logic [PORT_W-1:0] parent_q, n_parent;
    logic [NPORTS-1:0] child_q, n_child;
    logic [CNT_W-1:0]  req_q, n_req, done_q, n_done;
    logic              gflag_q, n_gflag;
    logic [DATA_W-1:0] res_q, n_res;
    logic [NPORTS-1:0] in_bit, out_bit;

    assign in_bit  = NPORTS'(1) << in_port_i;
    assign out_bit = NPORTS'(1) << out_port_i;

    // Identity value of each reduction operator.
    function automatic logic [DATA_W-1:0] ident(input logic [2:0] op);
        case (red_op_e'(op))
            OP_AND, OP_MIN: ident = '1;
            default:        ident = '0;
        endcase
    endfunction

    // Next-state of the record and its release decision.
    always_comb begin
        n_valid  = valid_q;
        n_flow   = flow_q;
        n_op     = op_q;
        n_parent = parent_q;
        n_child  = child_q;
        n_req    = req_q;
        n_done   = done_q;
        n_gflag  = gflag_q;
        n_res    = res_q;
        drain_o  = 1'b0;
        if (sel_i) begin
            if (!valid_q) begin
                n_valid  = 1'b1;
                n_flow   = flow_i;
                n_op     = op_i;
                n_parent = in_port_i;
                n_child  = (kind_i == EV_UPD_FWD) ? out_bit : '0;
                n_req    = (kind_i == EV_UPD_LOCAL) ? CNT_W'(1) : '0;
                n_done   = '0;
                n_gflag  = 1'b0;
                n_res    = ident(op_i);
            end else begin
                case (ev_kind_e'(kind_i))
                    EV_UPD_LOCAL:  n_req   = req_q + CNT_W'(1);
                    EV_UPD_FWD:    n_child = child_q | out_bit;
                    EV_COMPLETE: begin
                        n_done = done_q + CNT_W'(1);
                        n_res  = merged_i;
                    end
                    EV_GATHER_REQ: n_gflag = 1'b1;
                    EV_GATHER_RSP: begin
                        if ((child_q & in_bit) != '0) begin
                            n_child = child_q & ~in_bit;
                            n_res   = merged_i;
                        end
                    end
                    default: ;
                endcase
                if ((kind_i == EV_COMPLETE || kind_i == EV_GATHER_REQ ||
                     kind_i == EV_GATHER_RSP) && n_gflag &&
                    n_child == '0 && n_req == n_done) begin
                    drain_o = 1'b1;
                    n_valid = 1'b0;
                end
            end
        end
    end

    // Record registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            flow_q   <= '0;
            op_q     <= '0;
            parent_q <= '0;
            child_q  <= '0;
            req_q    <= '0;
            done_q   <= '0;
            gflag_q  <= 1'b0;
            res_q    <= '0;
        end else begin
            valid_q  <= n_valid;
            flow_q   <= n_flow;
            op_q     <= n_op;
            parent_q <= n_parent;
            child_q  <= n_child;
            req_q    <= n_req;
            done_q   <= n_done;
            gflag_q  <= n_gflag;
            res_q    <= n_res;
        end
    end

    assign valid_o    = valid_q;
    assign flow_o     = flow_q;
    assign op_o       = op_q;
    assign parent_o   = parent_q;
    assign children_o = child_q;
    assign res_o      = res_q;
    assign nres_o     = n_res;

endmodule

// File: rtl/redtab_top.sv
// Reduction flow table: one event per cycle is looked up by flow,
// applied to its record, and may emit a gather replication mask or a
// final response toward the parent. Assumes the upstream source holds
// an event while ev_ready is low or withdraws it.
module redtab_top #(
    parameter int ENTRIES = 16,
    parameter int FLOW_W  = 8,
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 8,
    parameter int NPORTS  = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PORT_W = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [2:0]        ev_kind,
    input  logic [FLOW_W-1:0] ev_flow,
    input  logic [2:0]        ev_op,
    input  logic [PORT_W-1:0] ev_in_port,
    input  logic [PORT_W-1:0] ev_out_port,
    input  logic [DATA_W-1:0] ev_data,
    output logic              rsp_valid,
    output logic [FLOW_W-1:0] rsp_flow,
    output logic [PORT_W-1:0] rsp_port,
    output logic [DATA_W-1:0] rsp_data,
    output logic              gq_valid,
    output logic [FLOW_W-1:0] gq_flow,
    output logic [NPORTS-1:0] gq_mask
);
    import redtab_pkg::*;

    logic [ENTRIES-1:0]             valid_v, sel_v, drain_v;
    logic [ENTRIES-1:0][FLOW_W-1:0] flow_v;
    logic [ENTRIES-1:0][2:0]        op_v;
    logic [ENTRIES-1:0][PORT_W-1:0] parent_v;
    logic [ENTRIES-1:0][NPORTS-1:0] child_v;
    logic [ENTRIES-1:0][DATA_W-1:0] res_v, nres_v;

    logic             hit, free_any, is_upd, alloc, accept;
    logic [IDX_W-1:0] hit_idx, free_idx;
    logic [DATA_W-1:0] merged;

    redtab_cam #(.ENTRIES(ENTRIES), .FLOW_W(FLOW_W)) u_cam (
        .valid_i    (valid_v),
        .flow_i     (flow_v),
        .key_i      (ev_flow),
        .hit_o      (hit),
        .hit_idx_o  (hit_idx),
        .free_any_o (free_any),
        .free_idx_o (free_idx)
    );

    // Event classification and backpressure.
    always_comb begin
        is_upd   = (ev_kind == EV_UPD_LOCAL) || (ev_kind == EV_UPD_FWD);
        ev_ready = !(ev_valid && is_upd && !hit && !free_any);
        accept   = ev_valid && ev_ready;
        alloc    = accept && is_upd && !hit;
    end

    redtab_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i  (op_v[hit_idx]),
        .acc_i (res_v[hit_idx]),
        .val_i (ev_data),
        .res_o (merged)
    );

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_ent
            assign sel_v[g] = (accept && hit && hit_idx == IDX_W'(g)) ||
                              (alloc && free_idx == IDX_W'(g));
            redtab_entry #(
                .FLOW_W(FLOW_W), .DATA_W(DATA_W),
                .CNT_W(CNT_W), .NPORTS(NPORTS)
            ) u_ent (
                .clk        (clk),
                .rst_n      (rst_n),
                .sel_i      (sel_v[g]),
                .kind_i     (ev_kind),
                .flow_i     (ev_flow),
                .op_i       (ev_op),
                .in_port_i  (ev_in_port),
                .out_port_i (ev_out_port),
                .merged_i   (merged),
                .valid_o    (valid_v[g]),
                .flow_o     (flow_v[g]),
                .op_o       (op_v[g]),
                .parent_o   (parent_v[g]),
                .children_o (child_v[g]),
                .res_o      (res_v[g]),
                .nres_o     (nres_v[g]),
                .drain_o    (drain_v[g])
            );
        end
    endgenerate

    // Registered response and gather replication outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_flow  <= '0;
            rsp_port  <= '0;
            rsp_data  <= '0;
            gq_valid  <= 1'b0;
            gq_flow   <= '0;
            gq_mask   <= '0;
        end else begin
            rsp_valid <= |drain_v;
            rsp_flow  <= ev_flow;
            rsp_port  <= parent_v[hit_idx];
            rsp_data  <= nres_v[hit_idx];
            gq_valid  <= accept && hit && (ev_kind == EV_GATHER_REQ) &&
                         (child_v[hit_idx] != '0);
            gq_flow   <= ev_flow;
            gq_mask   <= child_v[hit_idx];
        end
    end

endmodule

// File: rtl/redtab_checker.sv
// Protocol and state checks on the reduction flow table, bound to the top.
// Assumes the event kind encodings of redtab_pkg.
module redtab_checker #(
    parameter int ENTRIES = 16,
    parameter int NPORTS  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ev_valid,
    input logic               ev_ready,
    input logic [2:0]         ev_kind,
    input logic               rsp_valid,
    input logic               gq_valid,
    input logic [NPORTS-1:0]  gq_mask,
    input logic [ENTRIES-1:0] valid_v
);

    // R8: a stall only occurs when every slot is taken.
    p_stall_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_ready |-> &valid_v);

    // R8: a stall only holds back a presented update.
    p_stall_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_ready |-> ev_valid && (ev_kind == 3'd1 || ev_kind == 3'd2));

    // R5: a response follows an accepted completion or gather event.
    p_rsp_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(ev_valid && ev_ready &&
                            (ev_kind == 3'd3 || ev_kind == 3'd4 || ev_kind == 3'd5)));

    // R10: replication mask is never empty.
    p_gq_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gq_valid |-> gq_mask != '0);

    // R10: replication follows an accepted gather request.
    p_gq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gq_valid |-> $past(ev_valid && ev_ready && ev_kind == 3'd4));

    // R2: occupancy changes by at most one slot per cycle.
    p_one_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_v != $past(valid_v)) |-> $countones(valid_v ^ $past(valid_v)) == 1);

endmodule

bind redtab_top redtab_checker #(.ENTRIES(ENTRIES), .NPORTS(NPORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .ev_ready  (ev_ready),
    .ev_kind   (ev_kind),
    .rsp_valid (rsp_valid),
    .gq_valid  (gq_valid),
    .gq_mask   (gq_mask),
    .valid_v   (valid_v)
);

// File: tb/redtab_top_bench.sv
// Directed bench for the reduction flow table.
module redtab_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [2:0]  ev_kind = '0;
    logic [7:0]  ev_flow = '0;
    logic [2:0]  ev_op = '0;
    logic [1:0]  ev_in_port = '0;
    logic [1:0]  ev_out_port = '0;
    logic [15:0] ev_data = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_flow;
    logic [1:0]  rsp_port;
    logic [15:0] rsp_data;
    logic        gq_valid;
    logic [7:0]  gq_flow;
    logic [3:0]  gq_mask;

    int n_cmp = 0;
    int n_bad = 0;

    logic        c_rsp_v, c_gq_v, c_acc;
    logic [7:0]  c_rsp_flow;
    logic [1:0]  c_rsp_port;
    logic [15:0] c_rsp_data;
    logic [3:0]  c_gq_mask;

    always #5 clk = ~clk;

    redtab_top u_redtab_top (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_kind(ev_kind), .ev_flow(ev_flow), .ev_op(ev_op),
        .ev_in_port(ev_in_port), .ev_out_port(ev_out_port), .ev_data(ev_data),
        .rsp_valid(rsp_valid), .rsp_flow(rsp_flow), .rsp_port(rsp_port),
        .rsp_data(rsp_data), .gq_valid(gq_valid), .gq_flow(gq_flow),
        .gq_mask(gq_mask)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present one event, let one edge pass, capture the registered outputs.
    task automatic send(input logic [2:0] k, input logic [7:0] f,
                        input logic [2:0] op, input logic [1:0] ip,
                        input logic [1:0] dp, input logic [15:0] d);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = k; ev_flow = f; ev_op = op;
        ev_in_port = ip; ev_out_port = dp; ev_data = d;
        #1 c_acc = ev_ready;
        @(posedge clk);
        #1;
        c_rsp_v = rsp_valid; c_rsp_flow = rsp_flow; c_rsp_port = rsp_port;
        c_rsp_data = rsp_data; c_gq_v = gq_valid; c_gq_mask = gq_mask;
        ev_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "ev_ready", 32'(ev_ready), 1);
        check("R1", "rsp_valid", 32'(rsp_valid), 0);
        check("R1", "gq_valid", 32'(gq_valid), 0);
    endtask

    // R2: identity per opcode, parent port recorded from arrival.
    task automatic t_identity();
        for (int op = 0; op < 5; op++) begin
            send(3'd2, 8'(10 + op), 3'(op), 2'd3, 2'd1, 16'h0);
            send(3'd4, 8'(10 + op), 3'd0, 2'd0, 2'd0, 16'h0);
            check("R10", "gq mask", 32'(c_gq_mask), 32'h2);
            send(3'd5, 8'(10 + op), 3'd0, 2'd1, 2'd0, 16'h5A3C);
            check("R2", "rsp valid", 32'(c_rsp_v), 1);
            check("R2", "identity merge", 32'(c_rsp_data), 32'h5A3C);
            check("R2", "parent port", 32'(c_rsp_port), 3);
        end
    endtask

    // R4/R5: local sum, then gather with no children.
    task automatic t_sum();
        for (int i = 0; i < 3; i++) send(3'd1, 8'd1, 3'd0, 2'd2, 2'd0, 16'h0);
        send(3'd3, 8'd1, 3'd0, 2'd0, 2'd0, 16'd5);
        send(3'd3, 8'd1, 3'd0, 2'd0, 2'd0, 16'd7);
        send(3'd3, 8'd1, 3'd0, 2'd0, 2'd0, 16'd9);
        check("R4", "no early rsp", 32'(c_rsp_v), 0);
        send(3'd4, 8'd1, 3'd0, 2'd0, 2'd0, 16'h0);
        check("R10", "no replication without children", 32'(c_gq_v), 0);
        check("R5", "rsp valid", 32'(c_rsp_v), 1);
        check("R4", "sum", 32'(c_rsp_data), 21);
        check("R5", "flow", 32'(c_rsp_flow), 1);
        check("R5", "parent", 32'(c_rsp_port), 2);
    endtask

    // R6: gather waits for outstanding completion (max).
    task automatic t_wait();
        send(3'd1, 8'd2, 3'd4, 2'd1, 2'd0, 16'h0);
        send(3'd1, 8'd2, 3'd4, 2'd1, 2'd0, 16'h0);
        send(3'd3, 8'd2, 3'd0, 2'd0, 2'd0, 16'd3);
        send(3'd4, 8'd2, 3'd0, 2'd0, 2'd0, 16'h0);
        check("R6", "held while counts differ", 32'(c_rsp_v), 0);
        send(3'd3, 8'd2, 3'd0, 2'd0, 2'd0, 16'd8);
        check("R6", "rsp on last completion", 32'(c_rsp_v), 1);
        check("R4", "max", 32'(c_rsp_data), 8);
    endtask

    // R3/R7/R10: tree node with two children and one local op (xor).
    task automatic t_tree();
        send(3'd2, 8'd3, 3'd1, 2'd0, 2'd1, 16'h0);
        send(3'd2, 8'd3, 3'd1, 2'd0, 2'd2, 16'h0);
        send(3'd1, 8'd3, 3'd1, 2'd0, 2'd0, 16'h0);
        send(3'd3, 8'd3, 3'd0, 2'd0, 2'd0, 16'h000F);
        send(3'd4, 8'd3, 3'd0, 2'd0, 2'd0, 16'h0);
        check("R3", "gq valid", 32'(c_gq_v), 1);
        check("R3", "child mask", 32'(c_gq_mask), 32'h6);
        check("R5", "held while children pending", 32'(c_rsp_v), 0);
        send(3'd5, 8'd3, 3'd0, 2'd3, 2'd0, 16'h00FF);
        check("R7", "stray child no rsp", 32'(c_rsp_v), 0);
        send(3'd5, 8'd3, 3'd0, 2'd1, 2'd0, 16'h00F0);
        check("R7", "one child left", 32'(c_rsp_v), 0);
        send(3'd5, 8'd3, 3'd0, 2'd2, 2'd0, 16'h0001);
        check("R7", "rsp after last child", 32'(c_rsp_v), 1);
        check("R7", "merged xor, stray ignored", 32'(c_rsp_data), 32'h00FE);
        check("R5", "parent", 32'(c_rsp_port), 0);
    endtask

    // R5: released flow restarts with a fresh record (min).
    task automatic t_release();
        send(3'd1, 8'd1, 3'd3, 2'd1, 2'd0, 16'h0);
        send(3'd3, 8'd1, 3'd0, 2'd0, 2'd0, 16'h0040);
        send(3'd4, 8'd1, 3'd0, 2'd0, 2'd0, 16'h0);
        check("R5", "reused flow rsp", 32'(c_rsp_v), 1);
        check("R5", "fresh min result", 32'(c_rsp_data), 32'h0040);
        check("R5", "fresh parent", 32'(c_rsp_port), 1);
    endtask

    // R9: non-update events to unknown flows are dropped.
    task automatic t_unknown();
        send(3'd3, 8'd99, 3'd0, 2'd0, 2'd0, 16'd50);
        check("R9", "drop completion", 32'(c_rsp_v | c_gq_v), 0);
        send(3'd4, 8'd99, 3'd0, 2'd0, 2'd0, 16'h0);
        check("R9", "drop gather req", 32'(c_rsp_v | c_gq_v), 0);
        send(3'd5, 8'd99, 3'd0, 2'd1, 2'd0, 16'd60);
        check("R9", "drop gather rsp", 32'(c_rsp_v | c_gq_v), 0);
        send(3'd1, 8'd99, 3'd0, 2'd2, 2'd0, 16'h0);
        send(3'd3, 8'd99, 3'd0, 2'd0, 2'd0, 16'd4);
        send(3'd4, 8'd99, 3'd0, 2'd0, 2'd0, 16'h0);
        check("R9", "no state left behind", 32'(c_rsp_data), 4);
    endtask

    // R8: full table stalls a new flow only.
    task automatic t_full();
        for (int f = 0; f < 16; f++) begin
            send(3'd2, 8'(100 + f), 3'd0, 2'd0, 2'd1, 16'h0);
            check("R8", "fill accepted", 32'(c_acc), 1);
        end
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = 3'd1; ev_flow = 8'd200;
        #1 check("R8", "stall new flow when full", 32'(ev_ready), 0);
        ev_flow = 8'd100;
        #1 check("R8", "known flow not stalled", 32'(ev_ready), 1);
        ev_valid = 1'b0;
        send(3'd4, 8'd105, 3'd0, 2'd0, 2'd0, 16'h0);
        check("R10", "mask of full-table flow", 32'(c_gq_mask), 32'h2);
        send(3'd5, 8'd105, 3'd0, 2'd1, 2'd0, 16'd7);
        check("R5", "release frees slot", 32'(c_rsp_v), 1);
        send(3'd1, 8'd200, 3'd0, 2'd2, 2'd0, 16'h0);
        check("R8", "new flow accepted after release", 32'(c_acc), 1);
        send(3'd3, 8'd200, 3'd0, 2'd0, 2'd0, 16'd9);
        send(3'd4, 8'd200, 3'd0, 2'd0, 2'd0, 16'h0);
        check("R8", "new flow result", 32'(c_rsp_data), 9);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_sum();
        t_wait();
        t_tree();
        t_release();
        t_unknown();
        t_full();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule